// File: doc/BRIEF.md
# Dynamic Memory Cycle Controller with Refresh Arbitration

This block connects a simple request/acknowledge memory bus to a dynamic memory of 256 rows by 256 columns with one data bit per location. A requester presents a 16-bit address, a direction and a write bit. The controller then drives the row half of the address and then the column half over one 8-bit multiplexed address port, and it times the row strobe, the column strobe and the write-enable strobe. While a cycle runs, `busy` is high. `mfc` pulses once when the cycle has completed, and for a read the data is then valid.

An internal timer raises a refresh request at a fixed interval. That interval is the cell retention time divided by the 128 refresh rows. The arbiter grants this request ahead of any bus access that is waiting at the same time. The granted refresh is a strobe cycle that uses only the row strobe. During that cycle a 7-bit refresh counter drives the low row-address bits. The array is built as two halves of 128 rows, so one such cycle restores one row in each half. Refresh runs one row per interval, interleaved with normal traffic. An access that arrives while a refresh is in progress waits and starts as soon as the controller is idle again.

A requester raises `req_valid` and holds it, with stable operands, until it sees `mfc`. It then drops `req_valid` at once.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During and directly after reset, `busy` and `mfc` are 0 and `mem_ras_n`, `mem_cas_n` and `mem_we_n` are 1.
- R2: An access drives the row part (address bits 15:8) on `mem_addr` with `mem_ras_n` low and `mem_cas_n` high for exactly T_RCD cycles. It then drives the column part (bits 7:0) with both strobes low for exactly T_CAS cycles.
- R3: `mfc` is high for exactly one cycle, the first cycle after the column strobe rises. For a read, `rd_data` then holds the bit that the memory returned.
- R4: A write holds `mem_we_n` low during the column phase and presents `req_wdata` on `mem_din`. A read keeps `mem_we_n` high throughout. Data written can be read back from the same address, and neighbouring addresses are unaffected.
- R5: `busy` is high from the first row-strobe cycle through T_RP precharge cycles, in which both strobes are high. `busy` is low in the cycle after that.
- R6: A refresh starts every REF_INTERVAL = RETENTION_CYC/128 cycles while the controller is idle. It holds `mem_ras_n` low for T_RCD+T_CAS cycles, keeps `mem_cas_n` and `mem_we_n` high, and covers exactly one row.
- R7: The refresh row address is {0, counter}. The 7-bit counter starts at 0 after reset, advances by one after each refresh, and wraps from 127 to 0.
- R8: When a refresh request and an access request are both present in an idle cycle, the refresh is performed first.
- R9: An access that waits behind a refresh starts its row phase in the first idle cycle after that refresh's precharge, which is the single cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until `mfc` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address: row in bits 15:8, column in 7:0 |
| req_wdata | input | 1 | Bit to be written |
| busy | output | 1 | A memory or refresh cycle is in progress |
| mfc | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Bit returned by the last read |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 1 | Write data to the memory |
| mem_dout | input | 1 | Read data from the memory |

## Verification
Accesses are tried at the corner addresses 0x0000 and 0xFFFF, at a patterned row/column pair, and at two adjacent columns that are written with opposite bits. This separates row/column swapping, column aliasing and lost writes, and a read of a location never written shows that stale data is not returned. A request is also timed to land exactly on the cycle where refresh becomes due. This tells whether priority goes to refresh and whether the waiting access resumes one idle cycle after the precharge. A long idle stretch of more than 128 refreshes shows the interval spacing, the RAS-only shape and the counter wrap from 127 to 0.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_RFSH,
    ST_PRE
  } seq_state_t;

  // Length of a refresh strobe: same row-strobe hold as a full access.
  function automatic int unsigned rfsh_hold(input int unsigned rcd, input int unsigned cas);
    return rcd + cas;
  endfunction

  // Refresh period in clock cycles from retention time and row count.
  function automatic int unsigned rfsh_period(input int unsigned retention, input int unsigned rows);
    return retention / rows;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned INTERVAL = 1562,
  parameter int unsigned RC_W     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_grant,
  input  logic            ref_done,
  output logic            ref_req,
  output logic [RC_W-1:0] ref_cnt
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr     <= '0;
      ref_req <= 1'b0;
      ref_cnt <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)           ref_req <= 1'b1;
      else if (ref_grant) ref_req <= 1'b0;
      if (ref_done)       ref_cnt <= ref_cnt + 1'b1;
    end
  end

  AST_RCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_cnt == $past(ref_cnt) + 1'b1)); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req); // R6

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RP  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_req,
  input  logic       ref_req,
  output seq_state_t state,
  output logic       ref_grant,
  output logic       ref_done,
  output logic       acc_start,
  output logic       capture,
  output logic       ras_n,
  output logic       cas_n,
  output logic       busy,
  output logic       mfc
);
  localparam int unsigned HOLD = rfsh_hold(T_RCD, T_CAS);
  localparam int unsigned MAXL = max2(HOLD, T_RP);
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt;
  logic          row_last, col_last, rf_last, pre_last;

  assign row_last  = (state == ST_ROW)  && (cnt == CW'(T_RCD - 1));
  assign col_last  = (state == ST_COL)  && (cnt == CW'(T_CAS - 1));
  assign rf_last   = (state == ST_RFSH) && (cnt == CW'(HOLD - 1));
  assign pre_last  = (state == ST_PRE)  && (cnt == CW'(T_RP - 1));

  assign ref_grant = (state == ST_IDLE) && ref_req;
  assign acc_start = (state == ST_IDLE) && acc_req && !ref_req;
  assign ref_done  = rf_last;
  assign capture   = col_last;

  assign ras_n = !((state == ST_ROW) || (state == ST_COL) || (state == ST_RFSH));
  assign cas_n = (state != ST_COL);
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      mfc   <= 1'b0;
    end else begin
      mfc <= col_last;
      cnt <= cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (ref_grant)      state <= ST_RFSH;
          else if (acc_start) state <= ST_ROW;
        end
        ST_ROW:  if (row_last) begin state <= ST_COL; cnt <= '0; end
        ST_COL:  if (col_last) begin state <= ST_PRE; cnt <= '0; end
        ST_RFSH: if (rf_last)  begin state <= ST_PRE; cnt <= '0; end
        ST_PRE:  if (pre_last) begin state <= ST_IDLE; cnt <= '0; end
        default: begin state <= ST_IDLE; cnt <= '0; end
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R2

  AST_MFC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |=> !mfc); // R3

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy); // R5

  AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RFSH) |-> cas_n); // R6

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned PIN_W = 8,
  parameter int unsigned RC_W  = 7
) (
  input  seq_state_t       state,
  input  logic [PIN_W-1:0] row,
  input  logic [PIN_W-1:0] col,
  input  logic [RC_W-1:0]  rrow,
  output logic [PIN_W-1:0] pins
);
  logic [PIN_W-1:0] rrow_ext;

  generate
    if (PIN_W > RC_W) begin : g_pad
      assign rrow_ext = {{(PIN_W - RC_W){1'b0}}, rrow};
    end else begin : g_same
      assign rrow_ext = rrow[PIN_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (state)
      ST_COL:  pins = col;
      ST_RFSH: pins = rrow_ext;
      default: pins = row;
    endcase
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 16,
  parameter int unsigned RETENTION_CYC = 200000,
  parameter int unsigned T_RCD         = 2,
  parameter int unsigned T_CAS         = 2,
  parameter int unsigned T_RP          = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          busy,
  output logic          mfc,
  output logic          rd_data,
  output logic [AW/2-1:0] mem_addr,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic          mem_din,
  input  logic          mem_dout
);
  localparam int unsigned PIN_W    = AW / 2;
  localparam int unsigned RC_W     = PIN_W - 1;
  localparam int unsigned INTERVAL = rfsh_period(RETENTION_CYC, 1 << RC_W);

  seq_state_t       state;
  logic             ref_req, ref_grant, ref_done, acc_start, capture;
  logic [RC_W-1:0]  ref_cnt;
  logic [AW-1:0]    addr_q;
  logic             wr_q, wd_q;

  dram_refresh_timer #(.INTERVAL(INTERVAL), .RC_W(RC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_done(ref_done),
    .ref_req(ref_req), .ref_cnt(ref_cnt)
  );

  dram_cycle_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_req(req_valid), .ref_req(ref_req),
    .state(state), .ref_grant(ref_grant), .ref_done(ref_done),
    .acc_start(acc_start), .capture(capture), .ras_n(mem_ras_n),
    .cas_n(mem_cas_n), .busy(busy), .mfc(mfc)
  );

  dram_addr_mux #(.PIN_W(PIN_W), .RC_W(RC_W)) u_mux (
    .state(state), .row(addr_q[AW-1:PIN_W]), .col(addr_q[PIN_W-1:0]),
    .rrow(ref_cnt), .pins(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= 1'b0;
      rd_data <= 1'b0;
    end else begin
      if (acc_start) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        wd_q   <= req_wdata;
      end
      if (capture && !wr_q) rd_data <= mem_dout;
    end
  end

  assign mem_we_n = !((state == ST_COL) && wr_q);
  assign mem_din  = wd_q;

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> ref_req); // R8

  AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !busy) |=> (state == ST_RFSH)); // R8

  AST_WE_ONLY_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cas_n); // R4

endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RET        = 12800;
  localparam int INTERVAL   = RET / 128;
  localparam int T_RCD      = 2;
  localparam int T_CAS      = 2;
  localparam int T_RP       = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic busy, mfc, rd_data, mem_ras_n, mem_cas_n, mem_we_n, mem_din;
  logic [7:0] mem_addr;
  logic mem_dout = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_ctrl #(.AW(16), .RETENTION_CYC(RET), .T_RCD(T_RCD),
                      .T_CAS(T_CAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .mfc(mfc),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural memory and refresh monitor, sampled on falling edges.
  bit mem [int];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [7:0] ras_row;
  bit cas_seen, have_prev, wrap_seen;
  int ras_start, last_ref_start, ref_count = 0;
  int exp_rrow = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !mem_ras_n) begin
        ras_start = cyc; ras_row = mem_addr; cas_seen = 0;
      end
      if (!mem_cas_n) begin
        cas_seen = 1;
        if (prev_cas) begin
          if (!mem_we_n) mem[{ras_row, mem_addr}] = mem_din;
          mem_dout <= mem.exists({ras_row, mem_addr}) ? mem[{ras_row, mem_addr}] : 1'b0;
        end
      end
      if (!prev_ras && mem_ras_n && !cas_seen) begin
        chk(cyc - ras_start == T_RCD + T_CAS, "R6 refresh strobe width", cyc - ras_start, T_RCD + T_CAS);
        chk(ras_row == 8'(exp_rrow), "R7 refresh row", ras_row, exp_rrow);
        if (have_prev)
          chk(ras_start - last_ref_start == INTERVAL, "R6 refresh interval",
              ras_start - last_ref_start, INTERVAL);
        if (exp_rrow == 127) wrap_seen = 1;
        exp_rrow = (exp_rrow + 1) % 128;
        last_ref_start = ras_start; have_prev = 1;
        ref_count++;
      end
      if (!mem_ras_n && !cas_seen && !mem_we_n)
        chk(0, "R6 write strobe in row-only phase", 0, 1);
      prev_ras = mem_ras_n;
      prev_cas = mem_cas_n;
    end
  end

  task automatic wait_refresh_end();
    int c = ref_count;
    while (ref_count == c) @(negedge clk);
    @(negedge clk);
  endtask

  // One access, checked phase by phase (R2..R5).
  task automatic do_acc(input bit wr, input logic [15:0] a, input bit wd, input bit exp_rd);
    int rowc = 0, colc = 0, guard = 0;
    bit cas_last = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    do begin
      @(negedge clk); guard++;
      if (!mem_ras_n) chk(busy == 1'b1, "R5 busy under strobe", busy, 1);
      if (!mem_ras_n && mem_cas_n && colc == 0) begin
        rowc++;
        chk(mem_addr == a[15:8], "R2 row part", mem_addr, a[15:8]);
      end
      if (!mem_cas_n) begin
        colc++;
        chk(mem_addr == a[7:0], "R2 column part", mem_addr, a[7:0]);
        chk(mem_we_n == !wr, "R4 write strobe", mem_we_n, !wr);
      end
      if (!mfc) cas_last = !mem_cas_n;
    end while (!mfc && guard < 40);
    chk(mfc == 1'b1, "R3 completion seen", mfc, 1);
    chk(cas_last, "R3 mfc right after column strobe", cas_last, 1);
    chk(rowc == T_RCD, "R2 row phase length", rowc, T_RCD);
    chk(colc == T_CAS, "R2 column phase length", colc, T_CAS);
    chk(mem_ras_n && mem_cas_n && busy, "R5 precharge", {mem_ras_n, mem_cas_n, busy}, 3'b111);
    if (!wr) chk(rd_data == exp_rd, "R3 read data", rd_data, exp_rd);
    req_valid = 1'b0;
    for (int i = 1; i < T_RP; i++) begin
      @(negedge clk);
      chk(busy && mem_ras_n, "R5 precharge hold", busy, 1);
    end
    @(negedge clk);
    chk(!busy && !mfc, "R5 idle after precharge", {busy, mfc}, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !mfc && mem_ras_n && mem_cas_n && mem_we_n, "R1 reset outputs",
        {busy, mfc, mem_ras_n, mem_cas_n, mem_we_n}, 5'b00111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mfc && mem_ras_n && mem_cas_n && mem_we_n, "R1 after release",
        {busy, mfc, mem_ras_n, mem_cas_n, mem_we_n}, 5'b00111);
  endtask

  task automatic t_write_read();
    wait_refresh_end();
    do_acc(1, 16'h0000, 1, 0);
    do_acc(1, 16'hFFFF, 1, 0);
    do_acc(1, 16'hA55A, 1, 0);
    do_acc(1, 16'hA55B, 0, 0);
    do_acc(1, 16'h12C3, 1, 0);
    wait_refresh_end();
    do_acc(0, 16'h0000, 0, 1);   // R4
    do_acc(0, 16'hFFFF, 0, 1);   // R4
    do_acc(0, 16'hA55A, 0, 1);   // R4
    do_acc(0, 16'hA55B, 0, 0);   // R4 neighbour kept apart
    do_acc(0, 16'h12C3, 0, 1);   // R4
    do_acc(0, 16'h5A5A, 0, 0);   // R4 never written
  endtask

  // Request lands on the same edge where refresh becomes due (R8, R9).
  task automatic t_tie();
    int e, rrow;
    wait_refresh_end();
    e = last_ref_start;
    while (cyc != e + INTERVAL - 1) @(negedge clk);
    rrow = exp_rrow;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hA55A;
    @(negedge clk);
    chk(!mem_ras_n && mem_cas_n && mem_addr == 8'(rrow), "R8 refresh wins tie",
        {mem_ras_n, mem_cas_n, mem_addr}, {2'b01, 8'(rrow)});
    while (cyc != e + INTERVAL + T_RCD + T_CAS + T_RP) @(negedge clk);
    chk(!busy, "R9 single idle cycle after refresh", busy, 0);
    @(negedge clk);
    chk(!mem_ras_n && mem_cas_n && mem_addr == 8'hA5, "R9 waiting access starts",
        {mem_ras_n, mem_cas_n, mem_addr}, {2'b01, 8'hA5});
    while (!mfc) @(negedge clk);
    chk(rd_data == 1'b1, "R9 waiting access data", rd_data, 1);
    req_valid = 1'b0;
    repeat (T_RP) @(negedge clk);
    chk(!busy, "R9 back to idle", busy, 0);
  endtask

  task automatic t_wrap();
    while (ref_count < 131) @(negedge clk);
    chk(wrap_seen && exp_rrow != 0, "R7 counter wrapped 127 to 0", wrap_seen, 1);
    wait_refresh_end();
    do_acc(0, 16'h12C3, 0, 1);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_tie();
    t_wrap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule